// File: doc/BRIEF.md
# Key-Armed Watchdog with Reset Pulse

This block is a machine-cycle watchdog for a small microcontroller core. After any hardware reset it sits disarmed and ignores the machine-cycle tick. Software arms it by writing a two-byte key to the watchdog register address: first 1Eh, then E1h. Once armed, a 14-bit counter advances on every machine-cycle tick. No register write can stop it; only a hardware reset or its own overflow returns it to the disarmed state. Software keeps the system alive by writing the same two-byte key again, which clears the counter to zero.

When the counter wraps from its all-ones value, the block starts a reset pulse. The pulse lasts a fixed number of oscillator clocks, 98 by default. For the whole pulse it holds the internal core reset high. It also drives the external reset pin high, unless the reset-out disable bit is set; that bit comes from an auxiliary configuration register elsewhere. At the end of the pulse the watchdog is disarmed and waits for a new key.

The controller has three states. DISARMED moves to ARMED on a completed key. ARMED moves to PULSING on a counter wrap. PULSING moves back to DISARMED once the pulse length has elapsed. The key tracker has two states. KEY_WAIT moves to KEY_HALF on a write of 1Eh to the key address. KEY_HALF moves back to KEY_WAIT on any other write to that address, and reports a completed key when that write carries E1h. The key tracker is held in KEY_WAIT while a pulse is active.

Top module: `wdt_oneshot`

## Requirements
- R1: While reset is applied, and in the first cycle after it, both `core_rst` and `rst_pin` are 0. A hardware reset disarms the watchdog at any time, including during a pulse.
- R2: While disarmed, any number of `mc_tick` pulses never causes a reset pulse.
- R3: A write of 1Eh followed by a write of E1h, both at address A6h, arms the watchdog. Once armed, the tick that takes the count past its all-ones value (the 2^CNT_W-th tick) starts the pulse in the following cycle. One tick fewer does not start it.
- R4: The counter advances only in cycles where `mc_tick` is 1. Clock cycles without a tick leave the count unchanged.
- R5: A pulse holds `core_rst` high for exactly PULSE_LEN clock cycles.
- R6: With `rstout_dis` = 1, `rst_pin` stays 0 during a pulse while `core_rst` still lasts PULSE_LEN cycles. With `rstout_dis` = 0, `rst_pin` follows `core_rst`.
- R7: While armed, writes of values other than a complete key (00h, a lone 1Eh, E1h without a preceding 1Eh, FFh) neither stop nor reset the count.
- R8: A complete key written while armed clears the count to zero. The pulse then follows 2^CNT_W ticks after that write.
- R9: After 1Eh, a write of any value other than E1h (or 1Eh) to address A6h cancels the partial key. Writes to other addresses do not advance the key.
- R10: An E1h write at A6h that is not preceded by 1Eh has no effect.
- R11: After a pulse ends the watchdog is disarmed: further ticks cause no pulse until a new key is written.
- R12: Repeating 1Eh before E1h keeps the partial key alive, so the sequence 1Eh, 1Eh, E1h arms the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| mc_tick | input | 1 | One-clock strobe per machine cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rstout_dis | input | 1 | Suppresses the reset pin drive when 1 |
| core_rst | output | 1 | Internal reset, high for the whole pulse |
| rst_pin | output | 1 | Reset pin drive, high during the pulse unless suppressed |

## Verification
The hardest situation to reach from the ports is a service key that lands at an arbitrary count value, followed by an overflow measured exactly from that point. With the default width this would take thousands of ticks per trial. The bench therefore builds the block with an 8-bit counter, where the overflow point is 256 ticks. It sweeps the service point across the whole count range, and each trial checks that one tick short of 256 after the key gives no pulse and that the 256th tick does. Cancelled, stray and repeated key bytes are interleaved with ticks, so that arming or clearing by mistake would shift the overflow cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        CTL_DISARMED = 2'd0,
        CTL_ARMED    = 2'd1,
        CTL_PULSING  = 2'd2
    } ctl_state_t;

    typedef enum logic {
        KEY_WAIT = 1'b0,
        KEY_HALF = 1'b1
    } key_state_t;

endpackage

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'hA6,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h1E,
    parameter logic [DATA_W-1:0] KEY_SECOND = 8'hE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              key_done
);

    key_state_t state_q, state_d;
    logic       hit;

    assign hit = wr_en && (wr_addr == KEY_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KEY_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = KEY_WAIT;
        end else if (hit) begin
            unique case (state_q)
                KEY_WAIT: state_d = (wr_data == KEY_FIRST) ? KEY_HALF : KEY_WAIT;
                KEY_HALF: state_d = (wr_data == KEY_FIRST) ? KEY_HALF : KEY_WAIT;
                default:  state_d = KEY_WAIT;
            endcase
        end
    end

    always_comb begin
        key_done = 1'b0;
        unique case (state_q)
            KEY_HALF: key_done = !flush && hit && (wr_data == KEY_SECOND);
            default:  key_done = 1'b0;
        endcase
    end

endmodule

// File: rtl/wdt_cycle_cnt.sv
module wdt_cycle_cnt #(
    parameter int CNT_W = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic clear,
    output logic wrap
);

    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (clear)        cnt_q <= '0;
        else if (run && tick)  cnt_q <= cnt_q + 1'b1;
    end

    assign wrap = run && tick && !clear && (cnt_q == CNT_TOP);

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
#(
    parameter int PULSE_LEN = 98
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_done,
    input  logic wrap,
    output logic armed,
    output logic pulsing
);

    localparam int PCNT_W = $clog2(PULSE_LEN + 1);
    localparam logic [PCNT_W-1:0] PCNT_LAST = PCNT_W'(PULSE_LEN - 1);

    ctl_state_t        state_q, state_d;
    logic [PCNT_W-1:0] pcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CTL_DISARMED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      pcnt_q <= '0;
        else if (state_q == CTL_PULSING) pcnt_q <= pcnt_q + 1'b1;
        else                             pcnt_q <= '0;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTL_DISARMED: if (key_done)            state_d = CTL_ARMED;
            CTL_ARMED:    if (wrap)                state_d = CTL_PULSING;
            CTL_PULSING:  if (pcnt_q == PCNT_LAST) state_d = CTL_DISARMED;
            default:                               state_d = CTL_DISARMED;
        endcase
    end

    always_comb begin
        armed   = 1'b0;
        pulsing = 1'b0;
        unique case (state_q)
            CTL_ARMED:   armed   = 1'b1;
            CTL_PULSING: pulsing = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/wdt_oneshot.sv
module wdt_oneshot #(
    parameter int CNT_W     = 14,
    parameter int PULSE_LEN = 98,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'hA6,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h1E,
    parameter logic [DATA_W-1:0] KEY_SECOND = 8'hE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rstout_dis,
    output logic              core_rst,
    output logic              rst_pin
);

    logic key_done;
    logic armed;
    logic pulsing;
    logic wrap;

    wdt_keyseq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR),
        .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
    ) u_key (
        .clk(clk), .rst_n(rst_n), .flush(pulsing), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .key_done(key_done)
    );

    wdt_cycle_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(armed), .tick(mc_tick),
        .clear(!armed || key_done), .wrap(wrap)
    );

    wdt_ctrl #(.PULSE_LEN(PULSE_LEN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .key_done(key_done), .wrap(wrap),
        .armed(armed), .pulsing(pulsing)
    );

    assign core_rst = pulsing;
    assign rst_pin  = pulsing && !rstout_dis;

endmodule

// File: rtl/wdt_oneshot_chk.sv
module wdt_oneshot_chk #(
    parameter int PULSE_LEN = 98
) (
    input logic clk,
    input logic rst_n,
    input logic mc_tick,
    input logic rstout_dis,
    input logic core_rst,
    input logic rst_pin
);

    localparam int RUN_W = $clog2(PULSE_LEN + 2);

    logic [RUN_W-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        run_len <= '0;
        else if (core_rst) run_len <= run_len + 1'b1;
        else               run_len <= '0;
    end

    a_r5_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |-> (run_len < RUN_W'(PULSE_LEN)));

    a_r5_pulse_exact: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst) |-> (run_len == RUN_W'(PULSE_LEN)));

    a_r6_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rstout_dis |-> !rst_pin);

    a_r6_pin_within_core: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pin |-> core_rst);

    a_r3_start_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_rst) |-> $past(mc_tick));

endmodule

bind wdt_oneshot wdt_oneshot_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .rstout_dis(rstout_dis),
    .core_rst(core_rst), .rst_pin(rst_pin)
);

// File: tb/test_wdt_oneshot.sv
module test_wdt_oneshot;

    localparam int CLK_PERIOD = 10;
    localparam int TB_CNT_W   = 8;
    localparam int TB_PULSE   = 98;
    localparam int LIMIT      = 1 << TB_CNT_W;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       rstout_dis = 1'b0;
    logic       core_rst;
    logic       rst_pin;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wdt_oneshot #(.CNT_W(TB_CNT_W), .PULSE_LEN(TB_PULSE)) i_wdt_oneshot (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rstout_dis(rstout_dis),
        .core_rst(core_rst), .rst_pin(rst_pin)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 8'h00; wr_data = 8'h00;
    endtask

    task automatic arm();
        wr(8'hA6, 8'h1E);
        wr(8'hA6, 8'hE1);
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            @(negedge clk);
            mc_tick = 1'b1;
            repeat (n) @(negedge clk);
            mc_tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Counts cycles of an active pulse; call at the negedge where it is first seen.
    task automatic measure(input string req, input int exp_pin);
        int core_n = 0;
        int pin_n  = 0;
        while (core_rst && core_n < 1000) begin
            core_n++;
            if (rst_pin) pin_n++;
            @(negedge clk);
        end
        check({req, " core_rst length"}, core_n, TB_PULSE);
        check({req, " rst_pin length"}, pin_n, exp_pin);
    endtask

    task automatic expect_fire(input string req);
        ticks(LIMIT - 1);
        check({req, " no pulse one tick early"}, int'(core_rst), 0);
        ticks(1);
        check({req, " pulse on wrap tick"}, int'(core_rst), 1);
        measure(req, rstout_dis ? 0 : TB_PULSE);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: outputs idle in reset and just after release
        idle(3);
        check("R1 core_rst in reset", int'(core_rst), 0);
        check("R1 rst_pin in reset", int'(rst_pin), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 core_rst after reset", int'(core_rst), 0);
        check("R1 rst_pin after reset", int'(rst_pin), 0);

        // R2: disarmed ignores ticks
        ticks(LIMIT + 50);
        check("R2 no pulse while disarmed", int'(core_rst), 0);

        // R3 + R5: arm and overflow at exactly 2^CNT_W ticks
        arm();
        expect_fire("R3/R5");

        // R11: disarmed after the pulse
        ticks(LIMIT + 50);
        check("R11 no pulse after overflow without key", int'(core_rst), 0);

        // R4: clock cycles without a tick do not advance
        arm();
        ticks(LIMIT / 2);
        idle(40);
        ticks(LIMIT / 2 - 1);
        check("R4 idle cycles not counted", int'(core_rst), 0);
        ticks(1);
        check("R4 pulse on last tick", int'(core_rst), 1);
        measure("R4", TB_PULSE);

        // R7: stray writes while armed do not stop or clear the count
        arm();
        ticks(10);
        wr(8'hA6, 8'h00);
        wr(8'hA6, 8'h1E);
        wr(8'hA6, 8'h77);
        wr(8'hA6, 8'hE1);
        wr(8'hA6, 8'hFF);
        ticks(LIMIT - 11);
        check("R7 count kept through stray writes", int'(core_rst), 0);
        ticks(1);
        check("R7 still overflows", int'(core_rst), 1);
        measure("R7", TB_PULSE);

        // R8: service key at swept count values clears the counter
        for (int k = 1; k < LIMIT; k += 9) begin
            arm();
            ticks(k);
            check("R8 no pulse before service", int'(core_rst), 0);
            arm();
            expect_fire("R8");
        end

        // R10: lone E1h does not arm
        wr(8'hA6, 8'hE1);
        ticks(LIMIT + 20);
        check("R10 stray second byte ignored", int'(core_rst), 0);

        // R9: cancelled partial key does not arm; other addresses do not complete it
        wr(8'hA6, 8'h1E);
        wr(8'hA6, 8'h55);
        wr(8'hA6, 8'hE1);
        ticks(LIMIT + 20);
        check("R9 cancelled key does not arm", int'(core_rst), 0);
        wr(8'hA6, 8'h1E);
        wr(8'hA7, 8'hE1);
        wr(8'h8E, 8'hE1);
        wr(8'hA6, 8'h00);
        ticks(LIMIT + 20);
        check("R9 other address does not complete key", int'(core_rst), 0);

        // R12 + R6: repeated first byte still arms; pin suppressed, core pulse intact
        rstout_dis = 1'b1;
        wr(8'hA6, 8'h1E);
        wr(8'hA6, 8'h1E);
        wr(8'hA6, 8'hE1);
        ticks(LIMIT);
        check("R12 repeated first byte arms", int'(core_rst), 1);
        check("R6 pin quiet when disabled", int'(rst_pin), 0);
        measure("R6", 0);
        rstout_dis = 1'b0;

        // R1: hardware reset disarms while armed
        arm();
        ticks(LIMIT - 5);
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        ticks(LIMIT + 20);
        check("R1 reset disarms armed watchdog", int'(core_rst), 0);

        // R1: hardware reset cuts a pulse short
        arm();
        ticks(LIMIT);
        check("R1 pulse started", int'(core_rst), 1);
        idle(10);
        rst_n = 1'b0;
        #1;
        check("R1 reset clears pulse", int'(core_rst), 0);
        check("R1 reset clears pin", int'(rst_pin), 0);
        @(negedge clk); rst_n = 1'b1;
        ticks(LIMIT + 20);
        check("R1 disarmed after reset in pulse", int'(core_rst), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule